// File: doc/BRIEF.md
# Link Port Error and Status Register

This block is the 32-bit error and status word for one port of a serial packet link. The recovery state machines of the link drive it with one-cycle event pulses and with level signals that show which stopped state each direction is in. The block keeps a sticky record of each event until software acknowledges it. It also shows the live recovery states, the state of link initialisation and a few capability bits that never change.

Software reaches the word through a small register bus at one fixed address. A read returns the assembled word in the same cycle. A write clears each sticky bit whose write-data bit is 1 and leaves all other bits alone. Event and level inputs take effect on the clock edge at which they are sampled. The `port_ok` and `port_error` outputs repeat the link-up bit and the sticky port-error bit so that they can be wired straight to other logic.

Top module: `link_port_status`

## Requirements
- R1: After reset, a read at the register address returns 0xE000_0001, and `port_ok` and `port_error` are 0.
- R2: Bits 31, 30 and 29 (idle-sequence-2 supported, enabled and active) always read 1. Bit 27 (flow-control mode, 0 = receiver-controlled) always reads 0. Reserved bits 28, 23:21, 15:11, 7:5, 4 and 3 always read 0. Writes to any of these bits do nothing.
- R3: Bit 26 (output packet dropped), bit 25 (output failed) and bit 24 (output degraded) each set one cycle after their own event pulse, and stay set until software clears them.
- R4: Writing 1 to a sticky bit at the register address clears that bit. Writing 0 to a bit leaves it unchanged.
- R5: If a set event and a write-one-to-clear reach the same sticky bit in the same cycle, the bit ends up set.
- R6: Bit 18 shows the output retry-stopped level and bit 16 shows the output error-stopped level, each one cycle after the input. Bit 20 sets sticky when the retry-stopped level rises. Bit 17 sets sticky when the error-stopped level rises.
- R7: Bit 10 shows the input retry-stopped level and bit 8 shows the input error-stopped level, each one cycle later. Bit 9 sets sticky when the input error-stopped level rises.
- R8: Bit 19 sets on a received packet-retry pulse and clears on a received accept/not-accept pulse. If both arrive in the same cycle, the retry wins.
- R9: Bit 2 sets sticky on either an unrecoverable input-recovery error or on entry to the output fatal-error state. The `port_error` output always equals bit 2.
- R10: Bit 1 and `port_ok` follow the link-initialised input one cycle later. Bit 0 reads the opposite of bit 1. Bits 1 and 0 are never both 1.
- R11: Read data is 0 unless a read is addressed at the register offset. A write to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 32 | Write data (1 bits clear sticky bits) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ev_pkt_drop | input | 1 | Output port dropped a packet at the failed threshold |
| ev_fail_thresh | input | 1 | Failed error threshold reached |
| ev_degr_thresh | input | 1 | Degraded error threshold reached |
| ev_in_unrecov | input | 1 | Input recovery hit an unrecoverable error |
| ev_out_fatal | input | 1 | Output recovery entered the fatal-error state |
| rx_retry | input | 1 | Packet-retry control symbol received |
| rx_ack | input | 1 | Packet-accepted or packet-not-accepted received |
| out_rty_stop | input | 1 | Output is in the retry-stopped state |
| out_err_stop | input | 1 | Output is in the error-stopped state |
| in_rty_stop | input | 1 | Input is in the retry-stopped state |
| in_err_stop | input | 1 | Input is in the error-stopped state |
| link_init | input | 1 | Link is initialised |
| port_ok | output | 1 | Copy of the link-up bit |
| port_error | output | 1 | Copy of the sticky port-error bit |

## Verification
A sticky bit that is lost, or one that never clears, shows up on the next read of the word. Every sticky flop is read back within two cycles of its event and again after each clear attempt. An edge detector that triggers on a level rather than a rise shows a sticky bit set again after an all-ones write while the level stays high. That shows up in the sweep over all 32 combinations of the link-state inputs. A mix-up between the link-up and uninitialised flops shows up on `port_ok` and in bits 1:0 one cycle after `link_init` changes.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_STICKY = 7;

    // Bit positions software decodes
    localparam int P_IDLE_SUP   = 31;
    localparam int P_IDLE_EN    = 30;
    localparam int P_IDLE_ACT   = 29;
    localparam int P_FLOW_MODE  = 27;
    localparam int P_OUT_RETRD  = 19;
    localparam int P_OUT_RSTOP  = 18;
    localparam int P_OUT_ESTOP  = 16;
    localparam int P_IN_RSTOP   = 10;
    localparam int P_IN_ESTOP   = 8;
    localparam int P_LINK_OK    = 1;
    localparam int P_LINK_UNINI = 0;

    // Index of each sticky flop inside the sticky bank
    typedef enum logic [2:0] {
        SK_IN_ERR   = 3'd0,
        SK_PORT_ERR = 3'd1,
        SK_OUT_ERR  = 3'd2,
        SK_OUT_RTY  = 3'd3,
        SK_OUT_DEGR = 3'd4,
        SK_OUT_FAIL = 3'd5,
        SK_OUT_DROP = 3'd6
    } sticky_idx_e;

    // Word position of each sticky flop, indexed by sticky_idx_e
    localparam int STICKY_POS [NUM_STICKY] = '{9, 2, 17, 20, 24, 25, 26};

    // Link-state levels as presented by the recovery machines
    typedef struct packed {
        logic out_rty_stop;
        logic out_err_stop;
        logic in_rty_stop;
        logic in_err_stop;
        logic link_up;
    } lvl_t;

    // Registered live state shown in the word
    typedef struct packed {
        logic out_rty_stop;
        logic out_err_stop;
        logic in_rty_stop;
        logic in_err_stop;
        logic out_retried;
        logic ok;
        logic uninit;
    } live_t;

    // Constant part of the word: capability bits high, flow mode low
    function automatic logic [WORD_W-1:0] fixed_word();
        logic [WORD_W-1:0] w;
        w = '0;
        w[P_IDLE_SUP]  = 1'b1;
        w[P_IDLE_EN]   = 1'b1;
        w[P_IDLE_ACT]  = 1'b1;
        w[P_FLOW_MODE] = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/lps_sticky_bank.sv
module lps_sticky_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[i] <= 1'b0;
            end else begin
                // set takes priority over clear
                q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
            end
        end

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);

        assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);

        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
    end

endmodule

// File: rtl/lps_live_state.sv
module lps_live_state
    import lps_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lvl_t  lvl_i,
    input  logic  rx_retry_i,
    input  logic  rx_ack_i,
    output live_t live_o,
    output logic  out_rty_entry_o,
    output logic  out_err_entry_o,
    output logic  in_err_entry_o
);

    lvl_t lvl_q;
    logic retried_q;
    logic uninit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= '0;
            retried_q <= 1'b0;
            uninit_q  <= 1'b1;
        end else begin
            lvl_q    <= lvl_i;
            uninit_q <= ~lvl_i.link_up;
            if (rx_retry_i) begin
                retried_q <= 1'b1;
            end else if (rx_ack_i) begin
                retried_q <= 1'b0;
            end
        end
    end

    // Entry into a stopped state is a rise of its level
    always_comb begin
        out_rty_entry_o = lvl_i.out_rty_stop & ~lvl_q.out_rty_stop;
        out_err_entry_o = lvl_i.out_err_stop & ~lvl_q.out_err_stop;
        in_err_entry_o  = lvl_i.in_err_stop  & ~lvl_q.in_err_stop;
    end

    always_comb begin
        live_o.out_rty_stop = lvl_q.out_rty_stop;
        live_o.out_err_stop = lvl_q.out_err_stop;
        live_o.in_rty_stop  = lvl_q.in_rty_stop;
        live_o.in_err_stop  = lvl_q.in_err_stop;
        live_o.out_retried  = retried_q;
        live_o.ok           = lvl_q.link_up;
        live_o.uninit       = uninit_q;
    end

    assert_retry_sets_R8: assert property (@(posedge clk) disable iff (rst)
        rx_retry_i |=> live_o.out_retried);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_ack_i && !rx_retry_i) |=> !live_o.out_retried);

    assert_ok_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(live_o.ok && live_o.uninit));

    assert_link_follow_R10: assert property (@(posedge clk) disable iff (rst)
        lvl_i.link_up |=> (live_o.ok && !live_o.uninit));

endmodule

// File: rtl/lps_regmap.sv
module lps_regmap
    import lps_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h40
) (
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  live_t                 live_i,
    input  logic [NUM_STICKY-1:0] sticky_i,
    output logic [NUM_STICKY-1:0] clr_o,
    output logic [WORD_W-1:0]     rdata_o
);

    logic hit;
    logic write_hit;
    logic read_hit;
    logic [WORD_W-1:0] word;

    assign hit       = bus_sel && (bus_addr == OFFSET);
    assign write_hit = hit && bus_wr;
    assign read_hit  = hit && !bus_wr;

    always_comb begin
        for (int i = 0; i < NUM_STICKY; i++) begin
            clr_o[i] = write_hit && bus_wdata[STICKY_POS[i]];
        end
    end

    always_comb begin
        word = fixed_word();
        word[P_OUT_RETRD]  = live_i.out_retried;
        word[P_OUT_RSTOP]  = live_i.out_rty_stop;
        word[P_OUT_ESTOP]  = live_i.out_err_stop;
        word[P_IN_RSTOP]   = live_i.in_rty_stop;
        word[P_IN_ESTOP]   = live_i.in_err_stop;
        word[P_LINK_OK]    = live_i.ok;
        word[P_LINK_UNINI] = live_i.uninit;
        for (int i = 0; i < NUM_STICKY; i++) begin
            word[STICKY_POS[i]] = sticky_i[i];
        end
    end

    assign rdata_o = read_hit ? word : '0;

endmodule

// File: rtl/link_port_status.sv
module link_port_status
    import lps_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_pkt_drop,
    input  logic              ev_fail_thresh,
    input  logic              ev_degr_thresh,
    input  logic              ev_in_unrecov,
    input  logic              ev_out_fatal,
    input  logic              rx_retry,
    input  logic              rx_ack,
    input  logic              out_rty_stop,
    input  logic              out_err_stop,
    input  logic              in_rty_stop,
    input  logic              in_err_stop,
    input  logic              link_init,
    output logic              port_ok,
    output logic              port_error
);

    lvl_t                  lvl;
    live_t                 live;
    logic                  out_rty_entry;
    logic                  out_err_entry;
    logic                  in_err_entry;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky_clr;
    logic [NUM_STICKY-1:0] sticky_q;

    always_comb begin
        lvl.out_rty_stop = out_rty_stop;
        lvl.out_err_stop = out_err_stop;
        lvl.in_rty_stop  = in_rty_stop;
        lvl.in_err_stop  = in_err_stop;
        lvl.link_up      = link_init;
    end

    lps_live_state u_live (
        .clk             (clk),
        .rst             (rst),
        .lvl_i           (lvl),
        .rx_retry_i      (rx_retry),
        .rx_ack_i        (rx_ack),
        .live_o          (live),
        .out_rty_entry_o (out_rty_entry),
        .out_err_entry_o (out_err_entry),
        .in_err_entry_o  (in_err_entry)
    );

    always_comb begin
        sticky_set              = '0;
        sticky_set[SK_IN_ERR]   = in_err_entry;
        sticky_set[SK_PORT_ERR] = ev_in_unrecov | ev_out_fatal;
        sticky_set[SK_OUT_ERR]  = out_err_entry;
        sticky_set[SK_OUT_RTY]  = out_rty_entry;
        sticky_set[SK_OUT_DEGR] = ev_degr_thresh;
        sticky_set[SK_OUT_FAIL] = ev_fail_thresh;
        sticky_set[SK_OUT_DROP] = ev_pkt_drop;
    end

    lps_sticky_bank #(.N(NUM_STICKY)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (sticky_set),
        .clr_i (sticky_clr),
        .q_o   (sticky_q)
    );

    lps_regmap #(.ADDR_W(ADDR_W), .OFFSET(REG_OFFSET)) u_map (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .live_i    (live),
        .sticky_i  (sticky_q),
        .clr_o     (sticky_clr),
        .rdata_o   (bus_rdata)
    );

    assign port_ok    = live.ok;
    assign port_error = sticky_q[SK_PORT_ERR];

    assert_port_err_mirror_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == REG_OFFSET) |-> (bus_rdata[2] == port_error));

    assert_port_err_set_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_in_unrecov || ev_out_fatal) |=> port_error);

    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != REG_OFFSET) |-> (bus_rdata == 32'h0));

endmodule

// File: tb/link_port_status_tb.sv
module link_port_status_tb;

    localparam logic [7:0] OFF  = 8'h40;
    localparam logic [31:0] BASE = 32'hE000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic ev_pkt_drop, ev_fail_thresh, ev_degr_thresh, ev_in_unrecov, ev_out_fatal;
    logic rx_retry, rx_ack;
    logic out_rty_stop, out_err_stop, in_rty_stop, in_err_stop, link_init;
    logic port_ok, port_error;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    link_port_status #(.ADDR_W(8), .REG_OFFSET(OFF)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pkt_drop(ev_pkt_drop), .ev_fail_thresh(ev_fail_thresh),
        .ev_degr_thresh(ev_degr_thresh), .ev_in_unrecov(ev_in_unrecov),
        .ev_out_fatal(ev_out_fatal), .rx_retry(rx_retry), .rx_ack(rx_ack),
        .out_rty_stop(out_rty_stop), .out_err_stop(out_err_stop),
        .in_rty_stop(in_rty_stop), .in_err_stop(in_err_stop),
        .link_init(link_init), .port_ok(port_ok), .port_error(port_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_addr = OFF;
    endtask

    task automatic check_word(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(OFF, d);
        check(req, d, exp);
    endtask

    // drive one write over one clock edge, inputs changed at negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = OFF; bus_wdata = '0;
    endtask

    task automatic pulse_ev(input int k);
        case (k)
            0: ev_pkt_drop    = 1'b1;
            1: ev_fail_thresh = 1'b1;
            2: ev_degr_thresh = 1'b1;
            3: ev_in_unrecov  = 1'b1;
            default: ev_out_fatal = 1'b1;
        endcase
    endtask

    task automatic ev_off();
        ev_pkt_drop = 0; ev_fail_thresh = 0; ev_degr_thresh = 0;
        ev_in_unrecov = 0; ev_out_fatal = 0;
    endtask

    function automatic logic [31:0] ev_mask(input int k);
        case (k)
            0: return 32'h1 << 26;
            1: return 32'h1 << 25;
            2: return 32'h1 << 24;
            default: return 32'h1 << 2;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        logic [31:0] m;
        logic [4:0]  prev;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = OFF; bus_wdata = '0;
        ev_off(); rx_retry = 0; rx_ack = 0;
        out_rty_stop = 0; out_err_stop = 0; in_rty_stop = 0; in_err_stop = 0; link_init = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_word("R1 reset word", 32'hE000_0001);
        check("R1 port_ok", {31'd0, port_ok}, 32'd0);
        check("R1 port_error", {31'd0, port_error}, 32'd0);

        // R2 write ones everywhere: fixed and reserved bits unchanged
        wr(OFF, 32'hFFFF_FFFF);
        check_word("R2 fixed after all-ones write", 32'hE000_0001);
        wr(OFF, 32'h0000_0000);
        check_word("R2 fixed after zero write", 32'hE000_0001);

        // R3/R4/R5/R9 direct sticky events
        for (int k = 0; k < 5; k++) begin
            m = ev_mask(k);
            pulse_ev(k);
            @(negedge clk);
            ev_off();
            check_word("R3 sticky set", BASE | 32'h1 | m);
            if (k >= 3) check("R9 port_error mirror", {31'd0, port_error}, 32'd1);
            @(negedge clk);
            check_word("R3 sticky holds", BASE | 32'h1 | m);
            wr(OFF, ~m);
            check_word("R4 other-bit clear no effect", BASE | 32'h1 | m);
            pulse_ev(k);
            wr(OFF, m);
            ev_off();
            check_word("R5 set wins over clear", BASE | 32'h1 | m);
            wr(OFF, m);
            check_word("R4 write one clears", BASE | 32'h1);
            if (k >= 3) check("R9 port_error cleared", {31'd0, port_error}, 32'd0);
        end

        // R11 miss address read and write
        pulse_ev(1);
        @(negedge clk);
        ev_off();
        rd(8'h44, d);
        check("R11 miss read zero", d, 32'h0);
        wr(8'h44, 32'hFFFF_FFFF);
        check_word("R11 miss write ignored", BASE | 32'h1 | (32'h1 << 25));
        wr(OFF, 32'h1 << 25);
        check_word("R11 cleared at own offset", BASE | 32'h1);

        // R8 received retry flag
        rx_retry = 1; @(negedge clk); rx_retry = 0;
        check_word("R8 retry sets bit 19", BASE | 32'h1 | (32'h1 << 19));
        wr(OFF, 32'hFFFF_FFFF);
        check_word("R8 bit 19 not write-clearable", BASE | 32'h1 | (32'h1 << 19));
        rx_ack = 1; @(negedge clk); rx_ack = 0;
        check_word("R8 ack clears bit 19", BASE | 32'h1);
        rx_retry = 1; rx_ack = 1; @(negedge clk); rx_retry = 0; rx_ack = 0;
        check_word("R8 retry wins over ack", BASE | 32'h1 | (32'h1 << 19));
        rx_ack = 1; @(negedge clk); rx_ack = 0;
        check_word("R8 ack clears again", BASE | 32'h1);

        // R6/R7/R10 sweep of all level combinations
        prev = '0;
        for (int c = 0; c < 32; c++) begin
            logic [4:0]  lv;
            logic [4:0]  rise;
            logic [31:0] live_bits;
            logic [31:0] stk;
            lv = c[4:0];
            rise = lv & ~prev;
            out_rty_stop = lv[0]; out_err_stop = lv[1];
            in_rty_stop  = lv[2]; in_err_stop  = lv[3]; link_init = lv[4];
            @(negedge clk);
            live_bits = ({31'd0, lv[0]} << 18) | ({31'd0, lv[1]} << 16) |
                        ({31'd0, lv[2]} << 10) | ({31'd0, lv[3]} << 8) |
                        (lv[4] ? 32'h2 : 32'h1);
            stk = ({31'd0, rise[0]} << 20) | ({31'd0, rise[1]} << 17) |
                  ({31'd0, rise[3]} << 9);
            check_word("R6 R7 R10 level sweep", BASE | live_bits | stk);
            check("R10 port_ok", {31'd0, port_ok}, {31'd0, lv[4]});
            wr(OFF, 32'hFFFF_FFFF);
            check_word("R6 R7 no re-entry while level held", BASE | live_bits);
            prev = lv;
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule